// File: doc/BRIEF.md
# FFT Pass Sequencer with Column/Twiddle/Row Decomposition

This block schedules the work of an external FFT core that handles at most 256 points per job. When the transform is small enough for its data and coefficients to sit in local memory, the sequencer issues four jobs in order: coefficient load, data load, transform, and result store. The next transform cannot begin until the store has completed.

Larger transforms are treated as a matrix with V rows and H columns, stored row-major, where N = V·H and sample x(rH + c) sits at row r, column c. The sequencer first issues one V-point job per column, walking the column with a stride of H. It then streams every element, one per cycle, together with the exponent k of its correction factor e^(−j2πk/N). Last, it issues one H-point job per row with unit stride, and the result ends up in column order.

Each job is a one-cycle start pulse carrying an operation code, a base address, a stride and the log2 of its length. The sequencer then waits for the core's completion pulse before it issues anything further. The configuration is captured on the start pulse, and a one-cycle done pulse closes the transform.

Top module: `fft_pass_seq`

## Requirements
- R1: After reset, busy, done, jobStart and twValid are all 0.
- R2: When cfgLogN ≤ 8, the sequencer issues exactly four jobs with jobOp 0 (coefficient load), 1 (data load), 2 (transform) and 3 (store), in that order. Each has jobBase 0, jobStride 1 and jobLogLen = cfgLogN, and twValid stays 0.
- R3: jobStart is a one-cycle pulse. The first job appears the cycle after start is sampled. Every later job appears the cycle after the previous jobDone is sampled, or the cycle after the last twiddle element, and never while a job is outstanding.
- R4: When cfgLogN > 8, with H = 2^cfgLogH and V = N/H, the first H jobs are column jobs for c = 0..H−1 in ascending order. Each has jobOp 2, jobBase c, jobStride H and jobLogLen = cfgLogN − cfgLogH.
- R5: The cycle after the last column job's jobDone, twValid is high for exactly N consecutive cycles. In that window, element e has twAddr = e (row r = e/H, column c = e mod H) and twExp = (r·c) mod N.
- R6: The cycle after the last twiddle element, V row jobs are issued for r = 0..V−1. Each has jobOp 2, jobBase r·H, jobStride 1 and jobLogLen = cfgLogH.
- R7: done is a one-cycle pulse in the cycle after the final jobDone. busy is 1 from the cycle after start through the done cycle, and 0 after it.
- R8: cfgLogN and cfgLogH are captured when start is accepted. Later changes to them have no effect on any job field or twiddle output of the running transform.
- R9: A start pulse while busy is ignored and issues no extra jobs.
- R10: A jobDone pulse while no job is outstanding and the block is idle has no effect: busy stays 0 and no job is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transform, sampled when idle |
| cfgLogN | input | 5 | log2 of the transform length |
| cfgLogH | input | 5 | log2 of the row length H in large mode |
| busy | output | 1 | Transform in progress |
| done | output | 1 | One-cycle completion pulse |
| jobStart | output | 1 | One-cycle job request to the core |
| jobOp | output | 2 | Job operation: 0 coefficient load, 1 data load, 2 transform, 3 store |
| jobBase | output | 16 | Element address of the job's first sample |
| jobStride | output | 16 | Address step between samples of the job |
| jobLogLen | output | 5 | log2 of the job length |
| jobDone | input | 1 | Core completion pulse for the outstanding job |
| twValid | output | 1 | Twiddle element valid this cycle |
| twAddr | output | 16 | Element address for the twiddle multiply |
| twExp | output | 16 | Twiddle exponent (r·c) mod N |

## Verification
Every result has a fixed cycle relative to its cause. A job is due one cycle after start, or one cycle after the jobDone that released it. The twiddle stream begins one cycle after the final column completion and advances one element per cycle. The first row job follows the last element by one cycle, and done follows the final completion by one cycle. The bench keeps a cycle counter, notes the cycle of every completion it drives, and compares each observed event against the cycle it is due and against the fields the requirements give for it. A late, early or repeated event therefore counts as a failure, as does a wrong value.

// File: rtl/fft_seq_pkg.sv
package fft_seq_pkg;
  localparam int MAX_LOG_N   = 16;
  localparam int SMALL_LOG_N = 8;
  localparam int ADDR_W      = MAX_LOG_N;
  localparam int LOG_W       = $clog2(MAX_LOG_N + 1);
  localparam int OP_W        = 2;

  localparam logic [OP_W-1:0] OP_TW_LOAD   = 2'd0;
  localparam logic [OP_W-1:0] OP_DATA_LOAD = 2'd1;
  localparam logic [OP_W-1:0] OP_FFT       = 2'd2;
  localparam logic [OP_W-1:0] OP_STORE     = 2'd3;

  typedef enum logic [1:0] {PH_SMALL, PH_COL, PH_TW, PH_ROW} phase_e;

  typedef struct packed {
    logic   cfgLoad;
    logic   idxClr;
    logic   idxInc;
    logic   twClr;
    logic   twStep;
    phase_e phase;
  } ctrl_t;
endpackage

// File: rtl/fft_pass_seq_dp.sv
module fft_pass_seq_dp
  import fft_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [LOG_W-1:0]  cfgLogN,
  input  logic [LOG_W-1:0]  cfgLogH,
  output logic              idxLast,
  output logic              twLast,
  output logic [OP_W-1:0]   jobOp,
  output logic [ADDR_W-1:0] jobBase,
  output logic [ADDR_W-1:0] jobStride,
  output logic [LOG_W-1:0]  jobLogLen,
  output logic [ADDR_W-1:0] twAddr,
  output logic [ADDR_W-1:0] twExp
);
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] SMALL_LAST = ADDR_W'(3);

  logic [LOG_W-1:0]  logN, logH, logV;
  logic [ADDR_W-1:0] hSize, hLast, vLast, nMask;
  logic [ADDR_W-1:0] idx, twRow, twCol, acc;

  // captured configuration
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      logN <= '0;
      logH <= '0;
    end else if (ctl.cfgLoad) begin
      logN <= cfgLogN;
      logH <= cfgLogH;
    end
  end

  assign logV  = logN - logH;
  assign hSize = ONE << logH;
  assign hLast = hSize - ONE;
  assign vLast = (ONE << logV) - ONE;
  assign nMask = (ONE << logN) - ONE;   // wraps to all ones when N = 2^ADDR_W

  // job index: op step, column or row
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           idx <= '0;
    else if (ctl.idxClr) idx <= '0;
    else if (ctl.idxInc) idx <= idx + ONE;
  end

  always_comb begin
    unique case (ctl.phase)
      PH_SMALL: idxLast = (idx == SMALL_LAST);
      PH_COL:   idxLast = (idx == hLast);
      PH_ROW:   idxLast = (idx == vLast);
      default:  idxLast = 1'b0;
    endcase
  end

  always_comb begin
    jobOp     = OP_FFT;
    jobBase   = '0;
    jobStride = ONE;
    jobLogLen = logN;
    unique case (ctl.phase)
      PH_SMALL: jobOp = idx[OP_W-1:0];
      PH_COL: begin
        jobBase   = idx;
        jobStride = hSize;
        jobLogLen = logV;
      end
      PH_ROW: begin
        jobBase   = idx << logH;
        jobLogLen = logH;
      end
      default: ;
    endcase
  end

  // element walk with incremental exponent: acc = row * col
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      twRow <= '0;
      twCol <= '0;
      acc   <= '0;
    end else if (ctl.twClr) begin
      twRow <= '0;
      twCol <= '0;
      acc   <= '0;
    end else if (ctl.twStep) begin
      if (twCol == hLast) begin
        twCol <= '0;
        twRow <= twRow + ONE;
        acc   <= '0;
      end else begin
        twCol <= twCol + ONE;
        acc   <= acc + twRow;
      end
    end
  end

  assign twLast = (twRow == vLast) && (twCol == hLast);
  assign twAddr = (twRow << logH) | twCol;
  assign twExp  = acc & nMask;

  // R5
  tw_addr_seq_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.twStep && !twLast) |=> (twAddr == $past(twAddr) + ONE));

  // R5
  tw_row0_exp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.twStep && (twAddr < hSize)) |-> (twExp == '0));
endmodule

// File: rtl/fft_pass_seq_ctrl.sv
module fft_pass_seq_ctrl
  import fft_seq_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [LOG_W-1:0] cfgLogN,
  input  logic             jobDone,
  input  logic             idxLast,
  input  logic             twLast,
  output ctrl_t            ctl,
  output logic             jobStart,
  output logic             twValid,
  output logic             busy,
  output logic             done
);
  typedef enum logic [2:0] {S_IDLE, S_ISSUE, S_WAIT, S_TWID, S_FIN} state_e;

  state_e state, stateNx;
  phase_e phase, phaseNx;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      phase <= PH_SMALL;
    end else begin
      state <= stateNx;
      phase <= phaseNx;
    end
  end

  always_comb begin
    stateNx = state;
    phaseNx = phase;
    ctl     = '0;
    unique case (state)
      S_IDLE: if (start) begin
        ctl.cfgLoad = 1'b1;
        ctl.idxClr  = 1'b1;
        ctl.twClr   = 1'b1;
        phaseNx     = (cfgLogN > LOG_W'(SMALL_LOG_N)) ? PH_COL : PH_SMALL;
        stateNx     = S_ISSUE;
      end
      S_ISSUE: stateNx = S_WAIT;
      S_WAIT: if (jobDone) begin
        if (!idxLast) begin
          ctl.idxInc = 1'b1;
          stateNx    = S_ISSUE;
        end else if (phase == PH_COL) begin
          phaseNx = PH_TW;
          stateNx = S_TWID;
        end else begin
          stateNx = S_FIN;
        end
      end
      S_TWID: begin
        ctl.twStep = 1'b1;
        if (twLast) begin
          ctl.idxClr = 1'b1;
          phaseNx    = PH_ROW;
          stateNx    = S_ISSUE;
        end
      end
      S_FIN:   stateNx = S_IDLE;
      default: stateNx = S_IDLE;
    endcase
    ctl.phase = phase;
  end

  assign jobStart = (state == S_ISSUE);
  assign twValid  = (state == S_TWID);
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);

  // R3
  job_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    jobStart |=> !jobStart);

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R7
  done_after_core_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(jobDone));

  // R9
  start_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done && start) |=> busy);
endmodule

// File: rtl/fft_pass_seq.sv
module fft_pass_seq
  import fft_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [LOG_W-1:0]  cfgLogN,
  input  logic [LOG_W-1:0]  cfgLogH,
  output logic              busy,
  output logic              done,
  output logic              jobStart,
  output logic [OP_W-1:0]   jobOp,
  output logic [ADDR_W-1:0] jobBase,
  output logic [ADDR_W-1:0] jobStride,
  output logic [LOG_W-1:0]  jobLogLen,
  input  logic              jobDone,
  output logic              twValid,
  output logic [ADDR_W-1:0] twAddr,
  output logic [ADDR_W-1:0] twExp
);
  ctrl_t ctl;
  logic  idxLast, twLast;

  fft_pass_seq_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .cfgLogN  (cfgLogN),
    .jobDone  (jobDone),
    .idxLast  (idxLast),
    .twLast   (twLast),
    .ctl      (ctl),
    .jobStart (jobStart),
    .twValid  (twValid),
    .busy     (busy),
    .done     (done)
  );

  fft_pass_seq_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .cfgLogN   (cfgLogN),
    .cfgLogH   (cfgLogH),
    .idxLast   (idxLast),
    .twLast    (twLast),
    .jobOp     (jobOp),
    .jobBase   (jobBase),
    .jobStride (jobStride),
    .jobLogLen (jobLogLen),
    .twAddr    (twAddr),
    .twExp     (twExp)
  );
endmodule

// File: tb/fft_pass_seq_tb.sv
module fft_pass_seq_tb_top;
  import fft_seq_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              start = 1'b0;
  logic [LOG_W-1:0]  cfgLogN = '0;
  logic [LOG_W-1:0]  cfgLogH = '0;
  logic              busy, done, jobStart, twValid;
  logic [OP_W-1:0]   jobOp;
  logic [ADDR_W-1:0] jobBase, jobStride, twAddr, twExp;
  logic [LOG_W-1:0]  jobLogLen;
  logic              jobDone = 1'b0;

  fft_pass_seq dut_i (
    .clk(clk), .rstN(rstN), .start(start), .cfgLogN(cfgLogN), .cfgLogH(cfgLogH),
    .busy(busy), .done(done), .jobStart(jobStart), .jobOp(jobOp),
    .jobBase(jobBase), .jobStride(jobStride), .jobLogLen(jobLogLen),
    .jobDone(jobDone), .twValid(twValid), .twAddr(twAddr), .twExp(twExp)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int curLogN = 0, curLogH = 0, latency = 1;
  int expCount = 0, jobIdx = 0, twIdx = 0, twTotal = 0, doneCnt = 0;
  int expStartCyc = 0, lastDoneCyc = 0, pend = 0;
  bit outstanding = 0, strayDone = 0;

  always @(posedge clk) cyc++;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // core model and monitor, evaluated away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (jobStart) begin
        int eOp, eBase, eStride, eLen, hS;
        string req;
        chk(!outstanding && cyc == expStartCyc, "R3", "job issue cycle", cyc, expStartCyc);
        hS = 1 << curLogH;
        if (curLogN <= SMALL_LOG_N) begin
          req = "R2"; eOp = jobIdx; eBase = 0; eStride = 1; eLen = curLogN;
        end else if (jobIdx < hS) begin
          req = "R4"; eOp = 2; eBase = jobIdx; eStride = hS; eLen = curLogN - curLogH;
        end else begin
          req = "R6"; eOp = 2; eBase = (jobIdx - hS) << curLogH; eStride = 1; eLen = curLogH;
        end
        if (jobIdx < expCount) begin
          chk(jobOp == OP_W'(eOp), req, "jobOp", jobOp, eOp);
          chk(jobBase == ADDR_W'(eBase), req, "jobBase", jobBase, eBase);
          chk(jobStride == ADDR_W'(eStride), req, "jobStride", jobStride, eStride);
          chk(jobLogLen == LOG_W'(eLen), req, "jobLogLen", jobLogLen, eLen);
        end else begin
          chk(1'b0, "R9", "unexpected extra job index", jobIdx, expCount);
        end
        jobIdx++;
        outstanding = 1;
        pend = latency;
      end
      if (twValid) begin
        int r, c, eExp;
        r = twIdx >> curLogH;
        c = twIdx & ((1 << curLogH) - 1);
        eExp = (r * c) & ((1 << curLogN) - 1);
        if (twIdx == 0) chk(cyc == lastDoneCyc + 1, "R5", "twiddle start cycle", cyc, lastDoneCyc + 1);
        if (twIdx < twTotal) begin
          chk(twAddr == ADDR_W'(twIdx), "R5", "twAddr", twAddr, twIdx);
          chk(twExp == ADDR_W'(eExp), "R5", "twExp", twExp, eExp);
        end else begin
          chk(1'b0, "R5", "extra twiddle element", twIdx, twTotal);
        end
        twIdx++;
        expStartCyc = cyc + 1;
      end else if (twIdx > 0 && twIdx < twTotal) begin
        chk(1'b0, "R5", "gap in twiddle stream at element", twIdx, twTotal);
        twIdx = twTotal;
      end
      if (done) begin
        doneCnt++;
        chk(cyc == lastDoneCyc + 1, "R7", "done cycle", cyc, lastDoneCyc + 1);
      end
    end
    jobDone = 1'b0;
    if (outstanding) begin
      if (pend == 0) begin
        jobDone = 1'b1;
        outstanding = 0;
        lastDoneCyc = cyc;
        expStartCyc = cyc + 1;
      end else begin
        pend--;
      end
    end else if (strayDone) begin
      jobDone = 1'b1;
      strayDone = 0;
    end
  end

  task automatic run_fft(input int logN, input int logH, input int lat, input bit poke);
    curLogN = logN; curLogH = logH; latency = lat;
    jobIdx = 0; twIdx = 0; doneCnt = 0;
    if (logN <= SMALL_LOG_N) begin
      expCount = 4; twTotal = 0;
    end else begin
      expCount = (1 << logH) + (1 << (logN - logH));
      twTotal = 1 << logN;
    end
    @(negedge clk);
    cfgLogN = LOG_W'(logN); cfgLogH = LOG_W'(logH);
    start = 1'b1;
    expStartCyc = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R7", "busy after start", busy, 1);
    if (poke) begin
      repeat (4) @(negedge clk);
      cfgLogN = LOG_W'(12); cfgLogH = LOG_W'(1);   // R8: must not disturb the run
      start = 1'b1;                                 // R9: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 100000 && doneCnt == 0; i++) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R7", "busy after done", busy, 0);
    chk(doneCnt == 1, "R7", "done pulses", doneCnt, 1);
    chk(jobIdx == expCount, "R3", "jobs issued", jobIdx, expCount);
    chk(twIdx == twTotal, "R5", "twiddle elements", twIdx, twTotal);
    repeat (3) @(negedge clk);
    chk(jobIdx == expCount, "R9", "no jobs after done", jobIdx, expCount);
  endtask

  task automatic test_reset();
    repeat (2) @(negedge clk);
    chk(busy == 1'b0, "R1", "busy in reset", busy, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    chk(jobStart == 1'b0, "R1", "jobStart in reset", jobStart, 0);
    chk(twValid == 1'b0, "R1", "twValid in reset", twValid, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(busy == 1'b0 && jobStart == 1'b0, "R1", "idle after reset", busy, 0);
  endtask

  task automatic test_stray_done();
    expCount = 0; jobIdx = 0;
    strayDone = 1;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R10", "busy after stray jobDone", busy, 0);
    chk(jobIdx == 0, "R10", "jobs after stray jobDone", jobIdx, 0);
  endtask

  initial begin
    test_reset();
    test_stray_done();
    run_fft(8, 0, 2, 1'b0);    // R2 largest single-pass size
    run_fft(4, 3, 1, 1'b1);    // R2, R8, R9 small size with pokes
    run_fft(9, 4, 3, 1'b1);    // R4 R5 R6, R8 R9: H=16 V=32
    run_fft(12, 8, 1, 1'b0);   // R4 R5 R6: H=256 V=16
    run_fft(10, 2, 2, 1'b0);   // R4 R5 R6: H=4 V=256
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule